// File: doc/BRIEF.md
# Infrared-Capable Asynchronous Serial Port with Handshake

This block is a full-duplex asynchronous serial port for one-start, eight-data, one-stop character frames with no parity. All bit timing comes from an external tick that pulses once per sixteenth of a bit period. The block does not generate baud rates.

The transmitter has a one-byte holding register that is loaded from a parallel port. Each serial line can run in one of two modes:

- **Plain mode:** a level-coded line that idles high.
- **Infrared mode:** the line idles low and each zero bit is sent as a short high pulse.

The receiver works in the same two modes. It keeps the last completed byte in a one-byte holding register until that byte is read. Each line has its own polarity inversion.

The transmitter waits for the clear-to-send input unless it is told to ignore it. The clear-to-send level is always visible as status, and a change in either direction can latch an event flag. The request-to-send output works in one of two ways:

- **Automatic:** it is driven low while the receiver can take data and high once a new frame has begun while the holding register is still full.
- **Direct:** it follows a control bit.

Top module: `uart_irda_core`

## Requirements
- R1: A transmitted frame is a 0 start bit, data bits with the least significant bit first, and a 1 stop bit. Each bit lasts exactly 16 ticks. In plain mode with no inversion the line idles at 1, and the transmit state changes only on a tick.
- R2: In infrared mode the line idles at 0. A zero bit, including the start bit, drives the line to 1 for the first 3 ticks of its 16 and to 0 for the rest. A one bit leaves the line at 0.
- R3: When cfg_txpol is 1, tx_line is the inverse of its normal value. When cfg_rxpol is 1, rx_line is inverted before decoding. A value of 0 means no inversion in both cases.
- R4: While cfg_ignore_cts is 0 and cts_n is high, no frame starts and a loaded byte stays pending. Once cts_n goes low, or while cfg_ignore_cts is 1, the pending byte is sent.
- R5: cts_state_n follows cts_n after a two-flop synchronizer. While cfg_cts_evt_en is 1, any change of the synchronized level sets cts_evt, which stays set until cts_evt_clr is pulsed.
- R6: In plain mode the receiver detects the start bit at a low level and samples each bit at tick 8 of the bit. On completion it presents the byte on rx_data with rx_valid = 1, and rx_read clears rx_valid.
- R7: In infrared mode a high pulse seen at any tick of a bit period decodes as 0, and a bit period with no pulse decodes as 1.
- R8: A completed frame whose stop bit decodes as 0 is stored with rx_frame_err = 1. A frame with a good stop bit is stored with rx_frame_err = 0.
- R9: If a frame completes while rx_valid is still 1, the held byte is kept and rx_overrun is set. rx_overrun stays set across reads until ovr_clr is pulsed.
- R10: When cfg_rts_direct is 0, rts_n is 0 while reception is possible. rts_n is 1 while the holding register is full and a start bit has been detected. When cfg_rts_direct is 1, rts_n equals cfg_rts_level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_irda | input | 1 | 1 selects infrared pulse coding on both lines |
| cfg_txpol | input | 1 | 1 inverts the transmit line |
| cfg_rxpol | input | 1 | 1 inverts the receive line |
| cfg_ignore_cts | input | 1 | 1 lets the transmitter start regardless of cts_n |
| cfg_cts_evt_en | input | 1 | 1 enables latching of clear-to-send changes |
| cts_evt_clr | input | 1 | Pulse clears cts_evt |
| cfg_rts_direct | input | 1 | 1 drives rts_n from cfg_rts_level |
| cfg_rts_level | input | 1 | Level for rts_n in direct mode |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Pulse writes tx_data into the transmit holding register |
| tx_busy | output | 1 | Holding register full or frame in progress |
| tx_line | output | 1 | Serial transmit output |
| rx_line | input | 1 | Serial receive input (asynchronous) |
| rx_read | input | 1 | Pulse releases the receive holding register |
| ovr_clr | input | 1 | Pulse clears rx_overrun |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Receive holding register full |
| rx_frame_err | output | 1 | Held byte had a zero stop bit |
| rx_overrun | output | 1 | Sticky overrun flag |
| cts_n | input | 1 | Clear-to-send, active low (asynchronous) |
| cts_state_n | output | 1 | Synchronized clear-to-send level |
| cts_evt | output | 1 | Latched clear-to-send change |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The assertions assume the following about the inputs:
- tick16 is a single-cycle pulse spaced at least four clocks apart, so a synchronized line change always lands before the next sampling tick.
- The mode and polarity controls stay fixed while a frame is on either line.

The bench keeps to these assumptions in three ways:
- It generates the tick from a divide-by-four counter.
- It changes configuration only with loopback off and the receive line parked at the new idle level.
- It then waits longer than a frame and discards any byte decoded from the switch before it checks again.

// File: rtl/uart_irda_pkg.sv
package uart_irda_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } frame_phase_e;

endpackage

// File: rtl/uart_sync_chain.sv
module uart_sync_chain #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= {STAGES{RST_VAL}};
        else        sr_q <= sr_d;
    end

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/uart_tx_eng.sv
module uart_tx_eng
    import uart_irda_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int OVS       = 16,
    parameter int IR_PULSE  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 cfg_irda,
    input  logic                 cfg_txpol,
    input  logic                 cfg_ignore_cts,
    input  logic                 cts_sync_n,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_load,
    output logic                 tx_busy,
    output logic                 tx_line
);
    localparam int CNT_W  = $clog2(OVS);
    localparam int BITS_W = $clog2(DATA_BITS);
    localparam logic [CNT_W-1:0]  LAST     = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0]  PULSE_LN = CNT_W'(IR_PULSE);
    localparam logic [BITS_W-1:0] LAST_BIT = BITS_W'(DATA_BITS - 1);

    typedef struct packed {
        frame_phase_e         ph;
        logic [CNT_W-1:0]     cnt;
        logic [BITS_W-1:0]    bitn;
        logic [DATA_BITS-1:0] sh;
        logic [DATA_BITS-1:0] hold;
        logic                 full;
        logic                 line;
    } tx_regs_t;

    tx_regs_t r_d, r_q;
    logic     cts_ok;
    logic     raw_bit;
    logic     ir_pulse;

    assign cts_ok = cfg_ignore_cts | ~cts_sync_n;

    always_comb begin
        r_d = r_q;
        if (tx_load && !r_q.full) begin
            r_d.hold = tx_data;
            r_d.full = 1'b1;
        end
        if (tick16) begin
            if (r_q.ph == PH_IDLE) begin
                if (r_q.full && cts_ok) begin
                    r_d.ph   = PH_START;
                    r_d.cnt  = '0;
                    r_d.bitn = '0;
                    r_d.sh   = r_q.hold;
                    r_d.full = 1'b0;
                end
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    case (r_q.ph)
                        PH_START: r_d.ph = PH_DATA;
                        PH_DATA: begin
                            r_d.sh   = r_q.sh >> 1;
                            r_d.bitn = r_q.bitn + 1'b1;
                            if (r_q.bitn == LAST_BIT) r_d.ph = PH_STOP;
                        end
                        default: r_d.ph = PH_IDLE;
                    endcase
                end
            end
        end
        case (r_d.ph)
            PH_START: raw_bit = 1'b0;
            PH_DATA:  raw_bit = r_d.sh[0];
            default:  raw_bit = 1'b1;
        endcase
        ir_pulse = (r_d.ph != PH_IDLE) && !raw_bit && (r_d.cnt < PULSE_LN);
        r_d.line = (cfg_irda ? ir_pulse : raw_bit) ^ cfg_txpol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph   <= PH_IDLE;
            r_q.cnt  <= '0;
            r_q.bitn <= '0;
            r_q.sh   <= '0;
            r_q.hold <= '0;
            r_q.full <= 1'b0;
            r_q.line <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_busy = r_q.full || (r_q.ph != PH_IDLE);
    assign tx_line = r_q.line;

    frame_phase_e ph_w;
    assign ph_w = r_q.ph;

    AST_TX_TICK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16 |=> $stable(ph_w)); // R1
    AST_TX_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_w == PH_IDLE && !cfg_ignore_cts && cts_sync_n) |=> (ph_w == PH_IDLE)); // R4
endmodule

// File: rtl/uart_rx_eng.sv
module uart_rx_eng
    import uart_irda_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 cfg_irda,
    input  logic                 cfg_rxpol,
    input  logic                 rx_line,
    input  logic                 rx_read,
    input  logic                 ovr_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err,
    output logic                 rx_overrun,
    output logic                 ovr_pending
);
    localparam int CNT_W  = $clog2(OVS);
    localparam int BITS_W = $clog2(DATA_BITS);
    localparam logic [CNT_W-1:0]  LAST     = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0]  MID      = CNT_W'(OVS / 2);
    localparam logic [CNT_W-1:0]  IR_STOP  = CNT_W'((OVS * 5) / 8);
    localparam logic [BITS_W-1:0] LAST_BIT = BITS_W'(DATA_BITS - 1);

    typedef struct packed {
        frame_phase_e         ph;
        logic [CNT_W-1:0]     cnt;
        logic [BITS_W-1:0]    bitn;
        logic [DATA_BITS-1:0] sh;
        logic                 seen;
        logic [DATA_BITS-1:0] data;
        logic                 full;
        logic                 ferr;
        logic                 ovr;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic     line_s;
    logic     zero_now;
    logic     bit_val;
    logic     stop_ok;
    logic [CNT_W-1:0] stop_pt;

    uart_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rx_line ^ cfg_rxpol),
        .q     (line_s)
    );

    assign zero_now = cfg_irda ? line_s : ~line_s;
    assign stop_pt  = cfg_irda ? IR_STOP : MID;

    always_comb begin
        r_d     = r_q;
        bit_val = 1'b1;
        stop_ok = 1'b1;
        if (rx_read) begin
            r_d.full = 1'b0;
            r_d.ferr = 1'b0;
        end
        if (ovr_clr) r_d.ovr = 1'b0;
        if (tick16) begin
            if (r_q.ph == PH_IDLE) begin
                if (zero_now) begin
                    r_d.ph   = PH_START;
                    r_d.cnt  = CNT_W'(1);
                    r_d.bitn = '0;
                    r_d.seen = 1'b1;
                end
            end else begin
                r_d.cnt  = r_q.cnt + 1'b1;
                r_d.seen = r_q.seen | zero_now;
                case (r_q.ph)
                    PH_START: begin
                        if (!cfg_irda && r_q.cnt == MID && !zero_now) begin
                            r_d.ph = PH_IDLE;
                        end else if (r_q.cnt == LAST) begin
                            r_d.ph   = PH_DATA;
                            r_d.seen = 1'b0;
                        end
                    end
                    PH_DATA: begin
                        if (!cfg_irda && r_q.cnt == MID) begin
                            r_d.sh = {~zero_now, r_q.sh[DATA_BITS-1:1]};
                        end
                        if (r_q.cnt == LAST) begin
                            if (cfg_irda) begin
                                bit_val = ~(r_q.seen | zero_now);
                                r_d.sh  = {bit_val, r_q.sh[DATA_BITS-1:1]};
                            end
                            r_d.seen = 1'b0;
                            r_d.bitn = r_q.bitn + 1'b1;
                            if (r_q.bitn == LAST_BIT) r_d.ph = PH_STOP;
                        end
                    end
                    default: begin
                        if (r_q.cnt == stop_pt) begin
                            stop_ok = cfg_irda ? ~(r_q.seen | zero_now) : ~zero_now;
                            r_d.ph  = PH_IDLE;
                            if (r_q.full && !rx_read) begin
                                r_d.ovr = 1'b1;
                            end else begin
                                r_d.data = r_q.sh;
                                r_d.full = 1'b1;
                                r_d.ferr = ~stop_ok;
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph   <= PH_IDLE;
            r_q.cnt  <= '0;
            r_q.bitn <= '0;
            r_q.sh   <= '0;
            r_q.seen <= 1'b0;
            r_q.data <= '0;
            r_q.full <= 1'b0;
            r_q.ferr <= 1'b0;
            r_q.ovr  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_data      = r_q.data;
    assign rx_valid     = r_q.full;
    assign rx_frame_err = r_q.ferr;
    assign rx_overrun   = r_q.ovr;
    assign ovr_pending  = r_q.full && (r_q.ph != PH_IDLE);

    AST_RX_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_read) |=> (rx_valid && $stable(rx_data))); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !ovr_clr) |=> rx_overrun); // R9
    AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && !tick16) |=> !rx_valid); // R6
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic cfg_cts_evt_en,
    input  logic cts_evt_clr,
    input  logic cfg_rts_direct,
    input  logic cfg_rts_level,
    input  logic ovr_pending,
    output logic cts_sync_n,
    output logic cts_evt,
    output logic rts_n
);
    typedef struct packed {
        logic prev;
        logic evt;
        logic rts;
    } flow_regs_t;

    flow_regs_t r_d, r_q;
    logic       cts_s;

    uart_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (cts_n),
        .q     (cts_s)
    );

    always_comb begin
        r_d      = r_q;
        r_d.prev = cts_s;
        if (cts_evt_clr) r_d.evt = 1'b0;
        if (cfg_cts_evt_en && (cts_s != r_q.prev)) r_d.evt = 1'b1;
        r_d.rts  = cfg_rts_direct ? cfg_rts_level : ovr_pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.prev <= 1'b1;
            r_q.evt  <= 1'b0;
            r_q.rts  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cts_sync_n = cts_s;
    assign cts_evt    = r_q.evt;
    assign rts_n      = r_q.rts;

    AST_RTS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rts_direct && ovr_pending) |=> rts_n); // R10
    AST_CTS_EVT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cts_evt_en && (cts_s != r_q.prev)) |=> cts_evt); // R5
endmodule

// File: rtl/uart_irda_core.sv
module uart_irda_core #(
    parameter int DATA_BITS   = 8,
    parameter int OVS         = 16,
    parameter int IR_PULSE    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick16,
    input  logic                 cfg_irda,
    input  logic                 cfg_txpol,
    input  logic                 cfg_rxpol,
    input  logic                 cfg_ignore_cts,
    input  logic                 cfg_cts_evt_en,
    input  logic                 cts_evt_clr,
    input  logic                 cfg_rts_direct,
    input  logic                 cfg_rts_level,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_load,
    output logic                 tx_busy,
    output logic                 tx_line,
    input  logic                 rx_line,
    input  logic                 rx_read,
    input  logic                 ovr_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_frame_err,
    output logic                 rx_overrun,
    input  logic                 cts_n,
    output logic                 cts_state_n,
    output logic                 cts_evt,
    output logic                 rts_n
);
    logic cts_sync_n;
    logic ovr_pending;

    uart_flow_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_flow (
        .clk            (clk),
        .rst_n          (rst_n),
        .cts_n          (cts_n),
        .cfg_cts_evt_en (cfg_cts_evt_en),
        .cts_evt_clr    (cts_evt_clr),
        .cfg_rts_direct (cfg_rts_direct),
        .cfg_rts_level  (cfg_rts_level),
        .ovr_pending    (ovr_pending),
        .cts_sync_n     (cts_sync_n),
        .cts_evt        (cts_evt),
        .rts_n          (rts_n)
    );

    uart_tx_eng #(.DATA_BITS(DATA_BITS), .OVS(OVS), .IR_PULSE(IR_PULSE)) u_tx (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick16         (tick16),
        .cfg_irda       (cfg_irda),
        .cfg_txpol      (cfg_txpol),
        .cfg_ignore_cts (cfg_ignore_cts),
        .cts_sync_n     (cts_sync_n),
        .tx_data        (tx_data),
        .tx_load        (tx_load),
        .tx_busy        (tx_busy),
        .tx_line        (tx_line)
    );

    uart_rx_eng #(.DATA_BITS(DATA_BITS), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick16       (tick16),
        .cfg_irda     (cfg_irda),
        .cfg_rxpol    (cfg_rxpol),
        .rx_line      (rx_line),
        .rx_read      (rx_read),
        .ovr_clr      (ovr_clr),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err),
        .rx_overrun   (rx_overrun),
        .ovr_pending  (ovr_pending)
    );

    assign cts_state_n = cts_sync_n;
endmodule

// File: tb/test_uart_irda_core.sv
module test_uart_irda_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic cfg_irda = 0, cfg_txpol = 0, cfg_rxpol = 0, cfg_ignore_cts = 0;
    logic cfg_cts_evt_en = 0, cts_evt_clr = 0, cfg_rts_direct = 0, cfg_rts_level = 0;
    logic [7:0] tx_data = 8'h00;
    logic tx_load = 0, ovr_clr = 0, cts_n = 0;
    logic tx_busy, tx_line, rx_line, rx_read, rx_valid, rx_frame_err, rx_overrun;
    logic cts_state_n, cts_evt, rts_n;
    logic [7:0] rx_data;
    logic loop = 0, drv_line = 1, auto_read = 1, man_read = 0, done = 0;
    int   checks = 0, fails = 0;

    typedef struct {
        logic [7:0] d;
        logic       fe;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd3);
    end

    assign rx_line = loop ? tx_line : drv_line;
    assign rx_read = man_read | (auto_read & rx_valid);

    uart_irda_core i_uart_irda_core (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .cfg_irda(cfg_irda), .cfg_txpol(cfg_txpol), .cfg_rxpol(cfg_rxpol),
        .cfg_ignore_cts(cfg_ignore_cts), .cfg_cts_evt_en(cfg_cts_evt_en),
        .cts_evt_clr(cts_evt_clr), .cfg_rts_direct(cfg_rts_direct),
        .cfg_rts_level(cfg_rts_level), .tx_data(tx_data), .tx_load(tx_load),
        .tx_busy(tx_busy), .tx_line(tx_line), .rx_line(rx_line), .rx_read(rx_read),
        .ovr_clr(ovr_clr), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun), .cts_n(cts_n),
        .cts_state_n(cts_state_n), .cts_evt(cts_evt), .rts_n(rts_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected item per completed byte
    initial begin
        forever begin
            @(negedge clk);
            if (auto_read && rx_valid) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R6 unexpected byte", {24'h0, rx_data}, 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rx_data == e.d, "R6/R1 data", {24'h0, rx_data}, {24'h0, e.d});
                    chk(rx_frame_err == e.fe, "R8 frame flag",
                        {31'h0, rx_frame_err}, {31'h0, e.fe});
                end
            end
        end
    end

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (!tick16) @(negedge clk);
        end
    endtask

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk);
        while (tx_busy) @(negedge clk);
        tx_data = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic send_tx(input logic [7:0] b);
        exp_t e;
        e.d = b; e.fe = 1'b0;
        sb.push_back(e);
        load_tx(b);
    endtask

    task automatic drive_rx(input logic [7:0] b, input logic stopv);
        for (int k = 0; k < 10; k++) begin
            logic bv;
            bv = (k == 0) ? 1'b0 : (k == 9) ? stopv : b[k-1];
            for (int t = 0; t < 16; t++) begin
                wait_ticks(1);
                if (cfg_irda) drv_line = ((!bv && t < 3) ? 1'b1 : 1'b0) ^ cfg_rxpol;
                else          drv_line = bv ^ cfg_rxpol;
            end
        end
        wait_ticks(1);
        drv_line = (cfg_irda ? 1'b0 : 1'b1) ^ cfg_rxpol;
    endtask

    task automatic wait_drain(input string req);
        int n = 0;
        while (sb.size() != 0 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(sb.size() == 0, req, sb.size(), 0);
        @(negedge clk);
        while (tx_busy) @(negedge clk);
        wait_ticks(20);
    endtask

    task automatic pulse_read();
        man_read = 1'b1;
        @(negedge clk);
        man_read = 1'b0;
    endtask

    task automatic pulse_ovr_clr();
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
    endtask

    task automatic reconfig(input logic irda, input logic txp, input logic rxp);
        auto_read = 1'b0;
        loop      = 1'b0;
        drv_line  = (irda ? 1'b0 : 1'b1) ^ rxp;
        cfg_irda  = irda;
        cfg_txpol = txp;
        cfg_rxpol = rxp;
        wait_ticks(250);
        pulse_read();
        pulse_ovr_clr();
        auto_read = 1'b1;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // reset state
        chk(tx_line == 1'b1, "R1 idle level", tx_line, 1);
        chk(tx_busy == 1'b0, "R4 not busy", tx_busy, 0);
        chk(rx_valid == 1'b0, "R6 empty", rx_valid, 0);
        chk(rts_n == 1'b0, "R10 ready", rts_n, 0);
        chk(cts_evt == 1'b0, "R5 no event", cts_evt, 0);

        // R1/R6: plain loopback of several patterns
        loop = 1'b1;
        send_tx(8'hA5); send_tx(8'h3C); send_tx(8'h00); send_tx(8'hFF);
        wait_drain("R1 loopback drained");

        // R1: direct waveform, sampled mid-bit
        loop = 1'b0;
        load_tx(8'h96);
        @(negedge clk);
        while (tx_line == 1'b1) @(negedge clk);
        wait_ticks(8);
        chk(tx_line == 1'b0, "R1 start bit", tx_line, 0);
        for (int k = 0; k < 8; k++) begin
            logic [7:0] pat;
            pat = 8'h96;
            wait_ticks(16);
            chk(tx_line == pat[k], "R1 data bit lsb first", tx_line, pat[k]);
        end
        wait_ticks(16);
        chk(tx_line == 1'b1, "R1 stop bit", tx_line, 1);
        while (tx_busy) @(negedge clk);

        // R2: infrared transmit pulse shape
        reconfig(1'b1, 1'b0, 1'b0);
        chk(tx_line == 1'b0, "R2 ir idle low", tx_line, 0);
        begin
            int hi = 0, run = 0, maxrun = 0;
            load_tx(8'hF0);
            @(negedge clk);
            while (tx_busy) begin
                if (tx_line) begin run++; hi++; if (run > maxrun) maxrun = run; end
                else run = 0;
                @(negedge clk);
            end
            chk(hi == 60, "R2 total pulse clocks", hi, 60);
            chk(maxrun == 12, "R2 pulse width 3 ticks", maxrun, 12);
        end

        // R7: infrared loopback
        loop = 1'b1;
        send_tx(8'h55); send_tx(8'hC3);
        wait_drain("R7 ir loopback drained");

        // R3: polarity inversion on both lines
        reconfig(1'b0, 1'b1, 1'b1);
        chk(tx_line == 1'b0, "R3 inverted idle", tx_line, 0);
        loop = 1'b1;
        send_tx(8'h6E);
        wait_drain("R3 inverted plain drained");
        reconfig(1'b1, 1'b1, 1'b1);
        chk(tx_line == 1'b1, "R3 inverted ir idle", tx_line, 1);
        loop = 1'b1;
        send_tx(8'h81);
        wait_drain("R3 inverted ir drained");
        reconfig(1'b0, 1'b0, 1'b0);

        // R4: clear-to-send gating
        loop = 1'b1;
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        send_tx(8'h42);
        wait_ticks(100);
        chk(tx_busy == 1'b1, "R4 held while cts high", tx_busy, 1);
        chk(tx_line == 1'b1, "R4 line idle while held", tx_line, 1);
        chk(sb.size() == 1, "R4 nothing received", sb.size(), 1);
        cts_n = 1'b0;
        wait_drain("R4 sent after cts low");
        chk(cts_evt == 1'b0, "R5 event disabled", cts_evt, 0);
        cts_n = 1'b1;
        cfg_ignore_cts = 1'b1;
        send_tx(8'h99);
        wait_drain("R4 ignore cts");
        cfg_ignore_cts = 1'b0;

        // R5: status and change event
        cfg_cts_evt_en = 1'b1;
        repeat (4) @(negedge clk);
        chk(cts_state_n == 1'b1, "R5 status high", cts_state_n, 1);
        chk(cts_evt == 1'b0, "R5 no change yet", cts_evt, 0);
        cts_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(cts_state_n == 1'b0, "R5 status low", cts_state_n, 0);
        chk(cts_evt == 1'b1, "R5 falling change", cts_evt, 1);
        cts_evt_clr = 1'b1; @(negedge clk); cts_evt_clr = 1'b0;
        @(negedge clk);
        chk(cts_evt == 1'b0, "R5 cleared", cts_evt, 0);
        cts_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(cts_evt == 1'b1, "R5 rising change", cts_evt, 1);
        cts_evt_clr = 1'b1; @(negedge clk); cts_evt_clr = 1'b0;
        cfg_cts_evt_en = 1'b0;
        cts_n = 1'b0;

        // R8: framing error then a clean byte
        loop = 1'b0;
        begin
            exp_t e;
            e.d = 8'h5A; e.fe = 1'b1; sb.push_back(e);
            drive_rx(8'h5A, 1'b0);
            wait_ticks(20);
            e.d = 8'h11; e.fe = 1'b0; sb.push_back(e);
            drive_rx(8'h11, 1'b1);
        end
        wait_drain("R8 frames received");

        // R9/R10: overrun and automatic request-to-send
        auto_read = 1'b0;
        drive_rx(8'h21, 1'b1);
        wait_ticks(4);
        chk(rx_valid == 1'b1, "R6 byte held", rx_valid, 1);
        chk(rx_data == 8'h21, "R6 held data", rx_data, 8'h21);
        chk(rts_n == 1'b0, "R10 full but idle", rts_n, 0);
        fork
            drive_rx(8'h77, 1'b1);
            begin
                wait_ticks(40);
                chk(rts_n == 1'b1, "R10 pending overrun", rts_n, 1);
            end
        join
        wait_ticks(4);
        chk(rx_overrun == 1'b1, "R9 overrun set", rx_overrun, 1);
        chk(rx_data == 8'h21, "R9 held byte kept", rx_data, 8'h21);
        chk(rts_n == 1'b0, "R10 released after frame", rts_n, 0);
        pulse_read();
        @(negedge clk);
        chk(rx_valid == 1'b0, "R6 read clears", rx_valid, 0);
        chk(rx_overrun == 1'b1, "R9 sticky over read", rx_overrun, 1);
        pulse_ovr_clr();
        chk(rx_overrun == 1'b0, "R9 cleared", rx_overrun, 0);
        auto_read = 1'b1;

        // R10: direct drive
        cfg_rts_direct = 1'b1; cfg_rts_level = 1'b1;
        repeat (2) @(negedge clk);
        chk(rts_n == 1'b1, "R10 direct high", rts_n, 1);
        cfg_rts_level = 1'b0;
        repeat (2) @(negedge clk);
        chk(rts_n == 1'b0, "R10 direct low", rts_n, 0);
        cfg_rts_direct = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule